// File: doc/BRIEF.md
# Two-Wire Bus Register Access Slave

This block lets an external host reach a 256-entry byte register file over a two-wire serial bus. The host addresses the slave with a 7-bit device address. Its two upper bits are zero and its lower five bits come from strap inputs, which are taken while reset is held. After a write-direction address, the first data byte sets an internal register pointer and every later byte is stored at that pointer. After a read-direction address, the slave shifts out the register the pointer names. The pointer advances after each data byte in either direction.

A STOP clears the pointer, so any read that begins after a STOP starts at register 0x00. A repeated START keeps the pointer. This lets a write that only sets the pointer be followed at once by a read from that register. Both bus lines pass through a synchroniser and a glitch filter before START, STOP and clock edges are decoded. The slave drives SDA only as an open-drain pull-down. The rest of the chip reads and writes the same register file through a plain synchronous port.

Top module: `twb_reg_slave`

## Requirements
- R1: While `rst` is high, `sda_low_o` is 0 and the strap value is loaded as the low five bits of the device address. After `rst` falls, the device address no longer follows `strap_i`.
- R2: The address byte is sent MSB first and has the form {2'b00, strap, rw}, where rw=1 means read. On a match, the slave pulls SDA low for the ninth clock. On a mismatch, the slave never pulls SDA low and stores nothing until the next START.
- R3: In a write transfer, the first data byte after the address loads the register pointer. Each later data byte is written at the pointer. Every data byte is acknowledged on the ninth clock.
- R4: In a read transfer, the register at the pointer is shifted out MSB first. Each bit is driven after an SCL falling edge.
- R5: The pointer increases by one after every data byte stored or sent, and it wraps from 0xFF to 0x00. The byte that loads the pointer does not advance it.
- R6: A STOP that follows a matching address sets the pointer to 0x00. A read addressed after a STOP therefore returns register 0x00 first.
- R7: A repeated START leaves the pointer unchanged, so a pointer write followed by a repeated-START read returns the register just selected.
- R8: When the master answers a read byte with NACK (SDA high on the ninth clock), the slave releases SDA and sends no further bits until a new START.
- R9: The core port reads with one cycle of latency: `core_rdata_o` shows the register at `core_addr_i` one clock later. A core write with `core_we_i` high is visible both on the core port and to later bus reads.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN clock cycles (3 by default) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; strap is captured while high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_low_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| strap_i | input | 5 | Low five bits of the device address |
| core_addr_i | input | 8 | Core-side register address |
| core_we_i | input | 1 | Core-side write strobe |
| core_wdata_i | input | 8 | Core-side write data |
| core_rdata_o | output | 8 | Core-side registered read data |

## Verification
The hardest case to reach is the difference between STOP and repeated START at the pointer. The stimulus sets the pointer with a write, then either ends with STOP or moves straight into a repeated-START read. It then compares the first byte returned with register 0x00 in one case and with the selected register in the other. A second hard case is a sub-threshold pulse on SCL in the middle of a byte. The bus model injects a one-cycle high spike while SCL is low and checks that the stored byte is unchanged. Pointer wrap is reached by loading 0xFF and writing two bytes in one transfer.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } twb_state_e;
endpackage

// File: rtl/twb_filter.sv
module twb_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

  logic          meta_q;
  logic          sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      dout   <= 1'b1;
      cnt_q  <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      if (sync_q == dout) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        dout  <= sync_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R10
  filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(sync_q) == dout));
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  always_comb begin
    scl_rise = scl_f & ~scl_d;
    scl_fall = ~scl_f & scl_d;
    start_ev = scl_f & scl_d & sda_d & ~sda_f;
    stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
  end

  // R10
  cond_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(start_ev && stop_ev) && !(scl_rise && scl_fall));
endmodule

// File: rtl/twb_regmem.sv
module twb_regmem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_rdata,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (bus_we) begin
      mem[bus_waddr] <= bus_wdata;
    end else if (core_we) begin
      mem[core_addr] <= core_wdata;
    end
    bus_rdata  <= mem[bus_raddr];
    core_rdata <= mem[core_addr];
  end
endmodule

// File: rtl/twb_protocol.sv
module twb_protocol
  import twb_pkg::*;
#(
  parameter int AW      = 8,
  parameter int STRAP_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_f,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic [STRAP_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic [AW-1:0]      ptr_q,
  output logic               sda_low_q,
  output logic               mem_we_q,
  output logic [AW-1:0]      mem_waddr_q,
  output logic [BYTE_W-1:0]  mem_wdata_q
);
  localparam int HI_W = DEV_W - STRAP_W;

  twb_state_e        state_q;
  logic [3:0]        bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] tx_q;
  logic              matched_q;
  logic              rnw_q;
  logic              first_q;
  logic              mack_q;
  logic              addr_hit;

  assign addr_hit = (shreg_q[BYTE_W-1:1] == {{HI_W{1'b0}}, dev_addr});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      bitcnt_q    <= '0;
      shreg_q     <= '0;
      tx_q        <= '0;
      matched_q   <= 1'b0;
      rnw_q       <= 1'b0;
      first_q     <= 1'b0;
      mack_q      <= 1'b0;
      ptr_q       <= '0;
      sda_low_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_waddr_q <= '0;
      mem_wdata_q <= '0;
    end else begin
      mem_we_q <= 1'b0;
      if (start_ev) begin
        state_q   <= ST_ADDR;
        bitcnt_q  <= '0;
        sda_low_q <= 1'b0;
        matched_q <= 1'b0;
      end else if (stop_ev) begin
        state_q   <= ST_IDLE;
        sda_low_q <= 1'b0;
        if (matched_q) ptr_q <= '0;
        matched_q <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg_q  <= {shreg_q[BYTE_W-2:0], sda_f};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              if (addr_hit) begin
                sda_low_q <= 1'b1;
                matched_q <= 1'b1;
                rnw_q     <= shreg_q[0];
                first_q   <= 1'b1;
                state_q   <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (rnw_q) begin
                tx_q      <= rd_data;
                sda_low_q <= ~rd_data[BYTE_W-1];
                state_q   <= ST_RD;
              end else begin
                sda_low_q <= 1'b0;
                state_q   <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg_q  <= {shreg_q[BYTE_W-2:0], sda_f};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              sda_low_q <= 1'b1;
              state_q   <= ST_WR_ACK;
              if (first_q) begin
                ptr_q   <= shreg_q[AW-1:0];
                first_q <= 1'b0;
              end else begin
                mem_we_q    <= 1'b1;
                mem_waddr_q <= ptr_q;
                mem_wdata_q <= shreg_q;
                ptr_q       <= ptr_q + 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_low_q <= 1'b0;
              bitcnt_q  <= '0;
              state_q   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt_q == 4'd7) begin
                sda_low_q <= 1'b0;
                ptr_q     <= ptr_q + 1'b1;
                state_q   <= ST_RD_ACK;
              end else begin
                tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_low_q <= ~tx_q[BYTE_W-2];
                bitcnt_q  <= bitcnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q      <= rd_data;
                sda_low_q <= ~rd_data[BYTE_W-1];
                bitcnt_q  <= '0;
                state_q   <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  stop_ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_ev && matched_q) |=> (ptr_q == '0));

  // R7
  restart_ptr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> $stable(ptr_q));

  // R3
  write_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_q |-> (state_q == ST_WR_ACK && sda_low_q));

  // R8
  rd_ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD_ACK || state_q == ST_IDLE) |-> !sda_low_q);

  // R2
  drive_only_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_rise || $past(scl_rise)) |-> !$rose(sda_low_q));
endmodule

// File: rtl/twb_reg_slave.sv
module twb_reg_slave
  import twb_pkg::*;
#(
  parameter int AW       = 8,
  parameter int STRAP_W  = 5,
  parameter int FILT_LEN = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_low_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [AW-1:0]      core_addr_i,
  input  logic               core_we_i,
  input  logic [BYTE_W-1:0]  core_wdata_i,
  output logic [BYTE_W-1:0]  core_rdata_o
);
  localparam int NLINE = 2;

  logic [STRAP_W-1:0] dev_addr_q;
  logic [NLINE-1:0]   raw;
  logic [NLINE-1:0]   filt;
  logic               scl_rise, scl_fall, start_ev, stop_ev;
  logic [AW-1:0]      ptr;
  logic               bus_we;
  logic [AW-1:0]      bus_waddr;
  logic [BYTE_W-1:0]  bus_wdata;
  logic [BYTE_W-1:0]  bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) dev_addr_q <= strap_i;
  end

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    twb_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw[g]),
      .dout(filt[g])
    );
  end

  twb_cond_detect u_det (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (filt[1]),
    .sda_f   (filt[0]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  twb_protocol #(.AW(AW), .STRAP_W(STRAP_W)) u_proto (
    .clk        (clk),
    .rst        (rst),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_f      (filt[0]),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .dev_addr   (dev_addr_q),
    .rd_data    (bus_rdata),
    .ptr_q      (ptr),
    .sda_low_q  (sda_low_o),
    .mem_we_q   (bus_we),
    .mem_waddr_q(bus_waddr),
    .mem_wdata_q(bus_wdata)
  );

  twb_regmem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk       (clk),
    .bus_we    (bus_we),
    .bus_waddr (bus_waddr),
    .bus_wdata (bus_wdata),
    .bus_raddr (ptr),
    .bus_rdata (bus_rdata),
    .core_we   (core_we_i),
    .core_addr (core_addr_i),
    .core_wdata(core_wdata_i),
    .core_rdata(core_rdata_o)
  );

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(dev_addr_q));

  // R1
  reset_release_chk: assert property (@(posedge clk)
    $past(rst) |-> !sda_low_o);
endmodule

// File: tb/twb_reg_slave_test.sv
module twb_reg_slave_test;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_low_o;
  logic [4:0] strap = 5'h0B;
  logic [7:0] core_addr = '0;
  logic       core_we = 1'b0;
  logic [7:0] core_wdata = '0;
  logic [7:0] core_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam logic [7:0] AW_W = 8'h16;
  localparam logic [7:0] AW_R = 8'h17;

  localparam logic [15:0] VEC [6] = '{
    16'h03_3C, 16'h80_01, 16'h7F_FE, 16'hC4_5A, 16'h10_00, 16'hEE_81
  };

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_low_o;

  twb_reg_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_low_o(sda_low_o), .strap_i(strap),
    .core_addr_i(core_addr), .core_we_i(core_we),
    .core_wdata_i(core_wdata), .core_rdata_o(core_rdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: act %0d exp 0", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic b_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic b_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic b_write(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 3) begin
        wq(Q/2); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q/2 - 1);
      end else begin
        wq(Q);
      end
      scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q/2);
    ack = (sda_line == 1'b0);
    wq(Q/2); scl_m = 1'b0; wq(Q);
  endtask

  task automatic b_read(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q/2);
      d[i] = sda_line;
      wq(Q/2); scl_m = 1'b0;
    end
    wq(2);
    sda_m = give_ack ? 1'b0 : 1'b1;
    wq(Q - 2); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(2);
    sda_m = 1'b1; wq(Q - 2);
  endtask

  task automatic core_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); core_addr = a; core_wdata = d; core_we = 1'b1;
    @(negedge clk); core_we = 1'b0;
  endtask

  task automatic core_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); core_addr = a;
    wq(2); d = core_rdata;
  endtask

  initial begin
    bit         ack;
    logic [7:0] d;

    wq(5);
    chk(sda_low_o == 1'b0, "R1 released in reset", sda_low_o, 0);
    rst = 1'b0;
    wq(1);
    strap = 5'h15;
    wq(4);
    chk(sda_low_o == 1'b0, "R1 idle after reset", sda_low_o, 0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] p, x;
      p = VEC[v][15:8]; x = VEC[v][7:0];
      b_start(); b_write(AW_W, 0, ack); b_write(p, 0, ack); b_write(x, 0, ack); b_stop();
      b_start(); b_write(AW_W, 0, ack); b_write(p, 0, ack);
      b_start(); b_write(AW_R, 0, ack); b_read(0, d); b_stop();
      chk(d == x, "R7 R4 restart read", d, x);
      core_rd(p, d);
      chk(d == x, "R3 R9 stored byte", d, x);
    end

    b_start(); b_write(AW_W, 0, ack);
    chk(ack, "R2 strap address acked", ack, 1);
    b_stop();
    core_wr(8'h10, 8'h5A);
    b_start(); b_write(8'h2A, 0, ack);
    chk(!ack, "R1 R2 new strap not matched", ack, 0);
    b_write(8'h10, 0, ack);
    chk(!ack, "R2 ignored after mismatch", ack, 0);
    b_write(8'h77, 0, ack); b_stop();
    core_rd(8'h10, d);
    chk(d == 8'h5A, "R2 mismatch stores nothing", d, 8'h5A);

    b_start(); b_write(AW_W, 0, ack); b_write(8'h40, 0, ack);
    b_write(8'hA1, 0, ack); b_write(8'hB2, 0, ack); b_write(8'hC3, 0, ack);
    chk(ack, "R3 data byte acked", ack, 1);
    b_stop();
    core_rd(8'h40, d); chk(d == 8'hA1, "R3 first data", d, 8'hA1);
    core_rd(8'h41, d); chk(d == 8'hB2, "R5 increment", d, 8'hB2);
    core_rd(8'h42, d); chk(d == 8'hC3, "R5 increment", d, 8'hC3);

    core_wr(8'h00, 8'hA5); core_wr(8'h01, 8'h3C);
    b_start(); b_write(AW_R, 0, ack);
    chk(ack, "R2 read address acked", ack, 1);
    b_read(1, d); chk(d == 8'hA5, "R6 read after stop at 0", d, 8'hA5);
    b_read(0, d); chk(d == 8'h3C, "R5 read increment", d, 8'h3C);
    wq(Q);
    chk(sda_low_o == 1'b0, "R8 released after nack", sda_low_o, 0);
    wq(Q);
    chk(sda_low_o == 1'b0, "R8 no more bits", sda_low_o, 0);
    b_stop();

    b_start(); b_write(AW_W, 0, ack); b_write(8'hFF, 0, ack);
    b_write(8'h11, 0, ack); b_write(8'h22, 0, ack); b_stop();
    core_rd(8'hFF, d); chk(d == 8'h11, "R5 top register", d, 8'h11);
    core_rd(8'h00, d); chk(d == 8'h22, "R5 wrap to zero", d, 8'h22);

    b_start(); b_write(AW_W, 0, ack); b_write(8'h50, 0, ack);
    b_write(8'h96, 1, ack); b_stop();
    core_rd(8'h50, d); chk(d == 8'h96, "R10 scl glitch ignored", d, 8'h96);

    core_wr(8'h60, 8'hC3);
    core_rd(8'h60, d); chk(d == 8'hC3, "R9 core write read", d, 8'hC3);
    b_start(); b_write(AW_W, 0, ack); b_write(8'h60, 0, ack);
    b_start(); b_write(AW_R, 0, ack); b_read(0, d); b_stop();
    chk(d == 8'hC3, "R9 R7 core write seen on bus", d, 8'hC3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule